// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Handler

This block is the addressing layer of a single-wire slave device. A bit-level layer below it detects line resets, hands over each bit the master writes with a one-cycle strobe, and asks for one bit at the start of each read slot. The handler reads an 8-bit command after every line reset and then runs one of five exchanges against a 64-bit identity code given at its input: dumping the code, comparing it against a code sent by the master, skipping addressing, or taking part in a wired-AND search. One variant of the search is open only while the alarm input is high.

The block transmits by asking the bit layer to pull the line low (`tx_low`). Sending a 1 leaves the line released. When an exchange ends in favour of this device, `select_o` goes high and stays high until the next line reset, so that a memory-function layer can take over the line. A device that loses an exchange releases the line and ignores all traffic until the next line reset.

States: `ST_WAIT_RST` (dropped out or just powered up, waits for a line reset), `ST_CMD` (collects the command byte), `ST_READ_ID` (sends the code), `ST_MATCH` (compares written bits), `ST_SRCH_BIT` / `ST_SRCH_CMP` / `ST_SRCH_DIR` (sends the bit, sends its complement, reads the master's choice), `ST_SELECTED`. Transitions: any state goes to `ST_CMD` on `line_reset`. `ST_CMD` goes to `ST_READ_ID`, `ST_MATCH`, `ST_SRCH_BIT` or `ST_SELECTED` when the eighth command bit arrives, and to `ST_WAIT_RST` for an unknown byte or for an alarm search with no alarm pending. `ST_READ_ID` goes to `ST_SELECTED` after 64 read slots. `ST_MATCH` goes to `ST_WAIT_RST` on the first differing bit and to `ST_SELECTED` after 64 equal bits. The search states cycle BIT→CMP→DIR→BIT, leave for `ST_WAIT_RST` when the written bit differs, and go to `ST_SELECTED` after the 64th bit.

Top module: `owire_rom_ctrl`

## Requirements
- R1: After `rst_n` is released, `select_o` and `tx_low` are low, and every read or write slot is ignored until the first `line_reset` pulse.
- R2: A command is the 8 bits written after a line reset, taken least significant bit first; the codes are 33h read code, 55h match code, CCh skip, F0h search and ECh alarm search.
- R3: After 33h, 64 read slots return `id_code` bit 0 first up to bit 63 (bits 7:0 family code, 55:8 serial number, 63:56 CRC); a 0 is sent with `tx_low` high and a 1 with `tx_low` low, and `select_o` rises after the 64th slot.
- R4: After 55h, 64 write slots are compared with `id_code` in the same bit order; if all agree, `select_o` rises after the 64th slot.
- R5: In a match exchange, a write slot that differs from the device's bit drops the device out at that slot: `select_o` stays low and `tx_low` stays low until the next line reset.
- R6: CCh raises `select_o` on the slot that completes the command byte, with no further slots.
- R7: After F0h, each of the 64 bit positions takes two read slots returning the identity bit and then its complement, followed by one write slot; when all 64 written bits agree with the code, `select_o` rises after the last one.
- R8: In a search, a written bit that differs from the device's own bit drops the device out at that slot: it releases the line for every later slot and stays unselected until the next line reset.
- R9: ECh behaves as F0h when `alarm_pending` is high at the completing command bit, and otherwise drops the device out at once.
- R10: Any command byte other than the five codes leaves `select_o` low and the line released until the next line reset.
- R11: A `line_reset` pulse aborts any exchange; in the next cycle `select_o` is low and the command receiver starts again from bit 0.
- R12: Once `select_o` is high, further slots change neither `select_o` nor `tx_low` (which stays low) until a line reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_reset | input | 1 | One-cycle pulse: bit layer saw a reset pulse on the line |
| rx_valid | input | 1 | One-cycle strobe: a write slot finished, `rx_bit` holds its value |
| rx_bit | input | 1 | Bit written by the master |
| tx_req | input | 1 | One-cycle strobe: a read slot starts and consumes `tx_low` |
| id_code | input | 64 | Device identity, bit 0 sent first |
| alarm_pending | input | 1 | Alarm condition from the measurement logic |
| tx_low | output | 1 | Request to pull the line low in the current read slot |
| select_o | output | 1 | Device is addressed; memory layer may take over |

## Verification
A wrong internal state shows at the ports within one slot: a bit index that is off by one or a state that failed to advance changes the very next value presented on `tx_low`, or leaves `select_o` low or high in the cycle after the slot that should decide it. Dropping out at the wrong moment is exposed because the following read slot must return a released line. Sweeping the position of the differing bit over all 64 positions for both match and search, and sweeping all 256 command bytes, makes an error at any single index or code visible at the first slot it touches.

// File: rtl/owire_rom_pkg.sv
package owire_rom_pkg;

    parameter int unsigned CMD_W = 8;

    localparam logic [CMD_W-1:0] CMD_READ_ID  = 8'h33;
    localparam logic [CMD_W-1:0] CMD_MATCH_ID = 8'h55;
    localparam logic [CMD_W-1:0] CMD_SKIP_ID  = 8'hCC;
    localparam logic [CMD_W-1:0] CMD_SEARCH   = 8'hF0;
    localparam logic [CMD_W-1:0] CMD_ALM_SRCH = 8'hEC;

    typedef enum logic [3:0] {
        ST_WAIT_RST = 4'd0,
        ST_CMD      = 4'd1,
        ST_READ_ID  = 4'd2,
        ST_MATCH    = 4'd3,
        ST_SRCH_BIT = 4'd4,
        ST_SRCH_CMP = 4'd5,
        ST_SRCH_DIR = 4'd6,
        ST_SELECTED = 4'd7
    } rom_state_t;

endpackage

// File: rtl/owire_cmd_shift.sv
module owire_cmd_shift #(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned CNT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] byte_next,
    output logic             byte_done
);
    logic [WIDTH-1:0] sreg;
    logic [CNT_W-1:0] cnt;

    // Incoming bits enter at the top and move down: first bit ends in bit 0.
    assign byte_next = {bit_in, sreg[WIDTH-1:1]};
    assign byte_done = shift_en && (cnt == CNT_W'(WIDTH - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (clr) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (shift_en) begin
            sreg <= byte_next;
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/owire_bit_index.sv
module owire_bit_index #(
    parameter int unsigned LIMIT = 64,
    localparam int unsigned IDX_W = $clog2(LIMIT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [IDX_W-1:0] idx,
    output logic             at_last
);
    assign at_last = (idx == IDX_W'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (inc && !at_last) begin
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/owire_rom_ctrl.sv
module owire_rom_ctrl
    import owire_rom_pkg::*;
#(
    parameter int unsigned ID_W = 64,
    localparam int unsigned IDX_W = $clog2(ID_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_reset,
    input  logic            rx_valid,
    input  logic            rx_bit,
    input  logic            tx_req,
    input  logic [ID_W-1:0] id_code,
    input  logic            alarm_pending,
    output logic            tx_low,
    output logic            select_o
);
    rom_state_t        state, state_nx;
    logic [CMD_W-1:0]  cmd_next;
    logic              cmd_done;
    logic [IDX_W-1:0]  bit_idx;
    logic              bit_last;
    logic              idx_inc;
    logic              own_bit;

    // Command byte receiver, only listening while a command is expected.
    owire_cmd_shift #(.WIDTH(CMD_W)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (line_reset),
        .shift_en  (rx_valid && (state == ST_CMD) && !line_reset),
        .bit_in    (rx_bit),
        .byte_next (cmd_next),
        .byte_done (cmd_done)
    );

    // Position inside the identity code; restarts on every line reset.
    owire_bit_index #(.LIMIT(ID_W)) u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (line_reset),
        .inc     (idx_inc),
        .idx     (bit_idx),
        .at_last (bit_last)
    );

    assign own_bit = id_code[bit_idx];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT_RST;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and index advance
    always_comb begin
        state_nx = state;
        idx_inc  = 1'b0;
        if (line_reset) begin
            state_nx = ST_CMD;
        end else begin
            unique case (state)
                ST_WAIT_RST: state_nx = ST_WAIT_RST;
                ST_CMD: begin
                    if (cmd_done) begin
                        unique case (cmd_next)
                            CMD_READ_ID:  state_nx = ST_READ_ID;
                            CMD_MATCH_ID: state_nx = ST_MATCH;
                            CMD_SKIP_ID:  state_nx = ST_SELECTED;
                            CMD_SEARCH:   state_nx = ST_SRCH_BIT;
                            CMD_ALM_SRCH: state_nx = alarm_pending ? ST_SRCH_BIT
                                                                   : ST_WAIT_RST;
                            default:      state_nx = ST_WAIT_RST;
                        endcase
                    end
                end
                ST_READ_ID: begin
                    if (tx_req) begin
                        idx_inc = 1'b1;
                        if (bit_last) state_nx = ST_SELECTED;
                    end
                end
                ST_MATCH: begin
                    if (rx_valid) begin
                        if (rx_bit != own_bit) begin
                            state_nx = ST_WAIT_RST;
                        end else begin
                            idx_inc = 1'b1;
                            if (bit_last) state_nx = ST_SELECTED;
                        end
                    end
                end
                ST_SRCH_BIT: begin
                    if (tx_req) state_nx = ST_SRCH_CMP;
                end
                ST_SRCH_CMP: begin
                    if (tx_req) state_nx = ST_SRCH_DIR;
                end
                ST_SRCH_DIR: begin
                    if (rx_valid) begin
                        if (rx_bit != own_bit) begin
                            state_nx = ST_WAIT_RST;
                        end else begin
                            idx_inc  = 1'b1;
                            state_nx = bit_last ? ST_SELECTED : ST_SRCH_BIT;
                        end
                    end
                end
                ST_SELECTED: state_nx = ST_SELECTED;
                default:     state_nx = ST_WAIT_RST;
            endcase
        end
    end

    // Outputs: a 0 to send is a pull-down request.
    always_comb begin
        tx_low   = 1'b0;
        select_o = 1'b0;
        unique case (state)
            ST_READ_ID:  tx_low   = ~own_bit;
            ST_SRCH_BIT: tx_low   = ~own_bit;
            ST_SRCH_CMP: tx_low   = own_bit;
            ST_SELECTED: select_o = 1'b1;
            default: begin
                tx_low   = 1'b0;
                select_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/owire_rom_ctrl_sva.sv
module owire_rom_ctrl_sva (
    input logic clk,
    input logic rst_n,
    input logic line_reset,
    input logic rx_valid,
    input logic tx_req,
    input logic tx_low,
    input logic select_o
);
    // R11: a line reset always leaves the device unselected and released
    a_r11_reset_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        line_reset |=> (!select_o && !tx_low));

    // R12: selection holds until a line reset
    a_r12_selected_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (select_o && !line_reset) |=> select_o);

    // R12: a selected device never drives the line from this layer
    a_r12_no_drive_selected: assert property (@(posedge clk) disable iff (!rst_n)
        select_o |-> !tx_low);

    // R2: state only moves on a slot strobe or a line reset
    a_r2_moves_on_slots: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !tx_req && !line_reset) |=> ($stable(tx_low) && $stable(select_o)));

    // R6: selection is always the outcome of a slot
    a_r6_select_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(select_o) |-> $past(rx_valid || tx_req));
endmodule

bind owire_rom_ctrl owire_rom_ctrl_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_reset (line_reset),
    .rx_valid   (rx_valid),
    .tx_req     (tx_req),
    .tx_low     (tx_low),
    .select_o   (select_o)
);

// File: tb/owire_rom_ctrl_bench.sv
module owire_rom_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_reset = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_bit = 1'b0;
    logic        tx_req = 1'b0;
    logic [63:0] id_code;
    logic        alarm_pending = 1'b0;
    logic        tx_low;
    logic        select_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    owire_rom_ctrl u_owire_rom_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_reset    (line_reset),
        .rx_valid      (rx_valid),
        .rx_bit        (rx_bit),
        .tx_req        (tx_req),
        .id_code       (id_code),
        .alarm_pending (alarm_pending),
        .tx_low        (tx_low),
        .select_o      (select_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_line_reset();
        @(negedge clk); line_reset = 1'b1;
        @(negedge clk); line_reset = 1'b0;
    endtask

    task automatic wr_slot(input logic b);
        @(negedge clk); rx_bit = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic rd_slot(output logic b);
        @(negedge clk); b = ~tx_low; tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wr_slot(v[i]);
    endtask

    // Reads n slots, returns 1 when all of them saw a released line
    task automatic rd_released(input int n, output bit all_one);
        logic b;
        all_one = 1'b1;
        for (int i = 0; i < n; i++) begin
            rd_slot(b);
            if (b !== 1'b1) all_one = 1'b0;
        end
    endtask

    function automatic logic [7:0] crc8_lsb(input logic [55:0] d);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            logic fb = c[0] ^ d[i];
            c = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 1'b0, 1'b1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [55:0] body;
        logic [63:0] got;
        logic        b, b2;
        bit          rel;
        int          bad;

        body    = {48'hA5C3_1E7F_0B92, 8'h10};
        id_code = {crc8_lsb(body), body};

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(select_o == 1'b0 && tx_low == 1'b0, "R1 reset state", {select_o, tx_low}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: slots before the first line reset are ignored
        wr_byte(8'hCC);
        chk(select_o == 1'b0, "R1 skip ignored before line reset", select_o, 0);
        wr_byte(8'h33);
        rd_released(8, rel);
        chk(rel, "R1 reads released before line reset", rel, 1);

        // R3: read code
        pulse_line_reset();
        wr_byte(8'h33);
        got = '0;
        for (int i = 0; i < 64; i++) begin
            rd_slot(b);
            got[i] = b;
            if (i < 63) chk(select_o == 1'b0, "R3 not selected during dump", select_o, 0);
        end
        chk(got == id_code, "R3 code order", got, id_code);
        chk(got[7:0] == 8'h10, "R3 family code first", got[7:0], 8'h10);
        @(negedge clk);
        chk(select_o == 1'b1, "R3 selected after dump", select_o, 1);
        // R12: later slots leave selection and line alone
        rd_released(4, rel);
        wr_byte(8'h00);
        chk(rel && select_o == 1'b1, "R12 sticky selection", {rel, select_o}, 2'b11);
        pulse_line_reset();
        chk(select_o == 1'b0, "R11 reset clears selection", select_o, 0);

        // R4: full match
        wr_byte(8'h55);
        for (int i = 0; i < 64; i++) wr_slot(id_code[i]);
        @(negedge clk);
        chk(select_o == 1'b1, "R4 match selects", select_o, 1);

        // R5: mismatch at every position
        for (int k = 0; k < 64; k++) begin
            pulse_line_reset();
            wr_byte(8'h55);
            for (int i = 0; i < 64; i++) wr_slot(id_code[i] ^ (i == k));
            rd_released(3, rel);
            chk(select_o == 1'b0 && rel, $sformatf("R5 mismatch at bit %0d", k),
                {select_o, rel}, 2'b01);
        end

        // R6: skip
        pulse_line_reset();
        for (int i = 0; i < 7; i++) wr_slot(8'hCC >> i);
        @(negedge clk);
        chk(select_o == 1'b0, "R6 not selected before 8th bit", select_o, 0);
        wr_slot(1'b1);
        chk(select_o == 1'b1, "R6 skip selects", select_o, 1);

        // R7: full search pass
        pulse_line_reset();
        wr_byte(8'hF0);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            rd_slot(b); rd_slot(b2);
            if (b !== id_code[i] || b2 !== ~id_code[i]) bad++;
            wr_slot(id_code[i]);
        end
        chk(bad == 0, "R7 bit and complement", bad, 0);
        chk(select_o == 1'b1, "R7 search selects", select_o, 1);

        // R8: wrong direction at every position
        for (int k = 0; k < 64; k++) begin
            pulse_line_reset();
            wr_byte(8'hF0);
            bad = 0;
            for (int i = 0; i <= k; i++) begin
                rd_slot(b); rd_slot(b2);
                if (b !== id_code[i] || b2 !== ~id_code[i]) bad++;
                wr_slot(id_code[i] ^ (i == k));
            end
            rd_released(4, rel);
            chk(bad == 0 && rel && select_o == 1'b0, $sformatf("R8 drop at bit %0d", k),
                {bad[7:0], rel, select_o}, 10'b10);
        end

        // R9: alarm search, alarm pending
        alarm_pending = 1'b1;
        pulse_line_reset();
        wr_byte(8'hEC);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            rd_slot(b); rd_slot(b2);
            if (b !== id_code[i] || b2 !== ~id_code[i]) bad++;
            wr_slot(id_code[i]);
        end
        chk(bad == 0 && select_o == 1'b1, "R9 alarm search with alarm", {bad[7:0], select_o}, 1);
        // R9: no alarm
        alarm_pending = 1'b0;
        pulse_line_reset();
        wr_byte(8'hEC);
        rd_released(6, rel);
        wr_slot(id_code[0]);
        chk(rel && select_o == 1'b0, "R9 alarm search without alarm", {rel, select_o}, 2'b10);

        // R2, R10: every command byte
        for (int c = 0; c < 256; c++) begin
            logic exp_first;
            pulse_line_reset();
            wr_byte(8'(c));
            chk(select_o == (c == 8'hCC), $sformatf("R10 command %02h selection", c),
                select_o, (c == 8'hCC));
            exp_first = (c == 8'h33 || c == 8'hF0) ? id_code[0] : 1'b1;
            rd_slot(b);
            chk(b == exp_first, $sformatf("R2 command %02h first read", c), b, exp_first);
        end

        // R11: reset in the middle of a command byte restarts the receiver
        pulse_line_reset();
        for (int i = 0; i < 4; i++) wr_slot(8'h33 >> i);
        pulse_line_reset();
        wr_byte(8'hCC);
        chk(select_o == 1'b1, "R11 receiver restarts at bit 0", select_o, 1);
        // R11: reset in the middle of a dump restarts the code at bit 0
        pulse_line_reset();
        wr_byte(8'h33);
        for (int i = 0; i < 10; i++) rd_slot(b);
        pulse_line_reset();
        wr_byte(8'h33);
        got = '0;
        for (int i = 0; i < 64; i++) begin
            rd_slot(b);
            got[i] = b;
        end
        chk(got == id_code, "R11 dump restarts after reset", got, id_code);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule